// File: doc/BRIEF.md
# Multiprocessor-Format Serial Transmitter

This block is an asynchronous serial transmitter. It has a holding register that the host writes, and a separate shift register that drives the line. A host write places a character in the holding register and clears the data-empty flag. At the next baud tick while the line is free, the transmitter copies that character into the shift register, sets data-empty again and starts a frame. The frame is a low start bit, a 7- or 8-bit data field sent least significant bit first, an optional multiprocessor address/data flag, and one or two high stop bits.

At the tick that ends the last stop bit, the transmitter checks data-empty. If another character is waiting, the next start bit follows with no gap. If not, the transmitter raises the transmit-done flag and holds the line high. Each flag, ANDed with its enable input, drives a level interrupt request. A baud tick input from outside sets the bit period.

Top module: `mp_serial_tx`

## Requirements
- R1: After reset, txd is 1, data_empty is 1 and tx_done is 1.
- R2: A cycle with wr_en=1 stores wr_data in the holding register and clears both data_empty and tx_done on the next clock.
- R3: At a baud tick, if the line is idle and data_empty is 0, the holding register is loaded and data_empty returns to 1. The start bit (txd=0) is output from the cycle after that tick.
- R4: The data bits follow the start bit, least significant bit first: wr_data bits 0..7 when cfg_len7=0, or bits 0..6 when cfg_len7=1.
- R5: When cfg_mp_en=1, one extra bit equal to mp_bit follows the data. When cfg_mp_en=0, no extra bit is sent.
- R6: One stop bit (txd=1) is sent when cfg_two_stop=0, and two stop bits when cfg_two_stop=1.
- R7: txd changes only in the cycle after a baud tick, so every bit lasts exactly one tick period.
- R8: If data_empty is 0 at the tick that ends the final stop bit, the next frame's start bit begins at that tick with no idle bit, and tx_done stays 0.
- R9: If data_empty is 1 at the tick that ends the final stop bit, tx_done becomes 1 and txd stays 1 until a new frame is loaded.
- R10: irq_data_empty equals data_empty AND data_irq_en. irq_tx_done equals tx_done AND done_irq_en.
- R11: cfg_len7, cfg_two_stop, cfg_mp_en and mp_bit are sampled when a frame is loaded. Changing them later does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Host write of the holding register |
| wr_data | input | DATA_W | Character to send |
| cfg_len7 | input | 1 | 1: short data field (DATA_W-1 bits) |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_mp_en | input | 1 | 1: append multiprocessor bit |
| mp_bit | input | 1 | Value of the multiprocessor bit |
| data_irq_en | input | 1 | Enable for the data-empty request |
| done_irq_en | input | 1 | Enable for the transmit-done request |
| txd | output | 1 | Serial line, registered, idles high |
| data_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Transmission finished, line idle |
| irq_data_empty | output | 1 | Data-empty interrupt request (level) |
| irq_tx_done | output | 1 | Transmit-done interrupt request (level) |

## Verification
The bench uses the default DATA_W of 8 and generates a tick every four clocks. With these values the full 8-bit field, the 7-bit field that drops bit 7, and both multiprocessor bit values can each be observed bit by bit. The four clocks between ticks also show that txd holds steady within a bit. Back-to-back frames, the idle transition and configuration changes during a frame are checked at the exact tick where the stop-bit decision is made.

// File: rtl/mp_tx_pkg.sv
package mp_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_MPB   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;
endpackage

// File: rtl/mp_tx_hold.sv
module mp_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic              done_set,
    output logic [DATA_W-1:0] hold_data,
    output logic              empty,
    output logic              done
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              empty;
        logic              done;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (wr_en) begin
            h_d.hold  = wr_data;
            h_d.empty = 1'b0;
            h_d.done  = 1'b0;
        end else begin
            if (load)     h_d.empty = 1'b1;
            if (done_set) h_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.hold  <= '0;
            h_q.empty <= 1'b1;
            h_q.done  <= 1'b1;
        end else begin
            h_q <= h_d;
        end
    end

    assign hold_data = h_q.hold;
    assign empty     = h_q.empty;
    assign done      = h_q.done;

    AST_LOAD_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> empty); // R3
    AST_WRITE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!empty && !done)); // R2
endmodule

// File: rtl/mp_tx_engine.sv
module mp_tx_engine
    import mp_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              empty,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              cfg_len7,
    input  logic              cfg_two_stop,
    input  logic              cfg_mp_en,
    input  logic              mp_bit,
    output logic              load,
    output logic              done_set,
    output logic              txd
);
    localparam int CW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST_LONG  = CW'(DATA_W - 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(DATA_W - 2);

    typedef struct packed {
        tx_state_e         state;
        logic [DATA_W-1:0] sr;
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     last;
        logic              mp_en;
        logic              mp_val;
        logic              two;
        logic              stop2;
        logic              txd;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        load     = 1'b0;
        done_set = 1'b0;
        if (baud_tick) begin
            unique case (e_q.state)
                ST_IDLE: begin
                    load = !empty;
                end
                ST_START: begin
                    e_d.state = ST_DATA;
                    e_d.txd   = e_q.sr[0];
                    e_d.sr    = e_q.sr >> 1;
                    e_d.cnt   = '0;
                end
                ST_DATA: begin
                    if (e_q.cnt == e_q.last) begin
                        if (e_q.mp_en) begin
                            e_d.state = ST_MPB;
                            e_d.txd   = e_q.mp_val;
                        end else begin
                            e_d.state = ST_STOP;
                            e_d.txd   = 1'b1;
                            e_d.stop2 = 1'b0;
                        end
                    end else begin
                        e_d.txd = e_q.sr[0];
                        e_d.sr  = e_q.sr >> 1;
                        e_d.cnt = e_q.cnt + 1'b1;
                    end
                end
                ST_MPB: begin
                    e_d.state = ST_STOP;
                    e_d.txd   = 1'b1;
                    e_d.stop2 = 1'b0;
                end
                ST_STOP: begin
                    if (e_q.two && !e_q.stop2) begin
                        e_d.stop2 = 1'b1;
                        e_d.txd   = 1'b1;
                    end else begin
                        e_d.state = ST_IDLE;
                        e_d.txd   = 1'b1;
                        if (empty) done_set = 1'b1;
                        else       load     = 1'b1;
                    end
                end
                default: begin
                    e_d.state = ST_IDLE;
                    e_d.txd   = 1'b1;
                end
            endcase
            if (load) begin
                e_d.state  = ST_START;
                e_d.txd    = 1'b0;
                e_d.sr     = hold_data;
                e_d.last   = cfg_len7 ? LAST_SHORT : LAST_LONG;
                e_d.mp_en  = cfg_mp_en;
                e_d.mp_val = mp_bit;
                e_d.two    = cfg_two_stop;
                e_d.stop2  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q.state  <= ST_IDLE;
            e_q.sr     <= '0;
            e_q.cnt    <= '0;
            e_q.last   <= LAST_LONG;
            e_q.mp_en  <= 1'b0;
            e_q.mp_val <= 1'b0;
            e_q.two    <= 1'b0;
            e_q.stop2  <= 1'b0;
            e_q.txd    <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign txd = e_q.txd;

    AST_IDLE_IS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.state == ST_IDLE) |-> e_q.txd); // R9
    AST_LOAD_GIVES_START: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd); // R3
    AST_BIT_HELD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd)); // R7
endmodule

// File: rtl/mp_serial_tx.sv
module mp_serial_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_len7,
    input  logic              cfg_two_stop,
    input  logic              cfg_mp_en,
    input  logic              mp_bit,
    input  logic              data_irq_en,
    input  logic              done_irq_en,
    output logic              txd,
    output logic              data_empty,
    output logic              tx_done,
    output logic              irq_data_empty,
    output logic              irq_tx_done
);
    logic [DATA_W-1:0] hold_data;
    logic              load;
    logic              done_set;

    mp_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .load      (load),
        .done_set  (done_set),
        .hold_data (hold_data),
        .empty     (data_empty),
        .done      (tx_done)
    );

    mp_tx_engine #(.DATA_W(DATA_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_tick    (baud_tick),
        .empty        (data_empty),
        .hold_data    (hold_data),
        .cfg_len7     (cfg_len7),
        .cfg_two_stop (cfg_two_stop),
        .cfg_mp_en    (cfg_mp_en),
        .mp_bit       (mp_bit),
        .load         (load),
        .done_set     (done_set),
        .txd          (txd)
    );

    assign irq_data_empty = data_empty & data_irq_en;
    assign irq_tx_done    = tx_done & done_irq_en;

    AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> txd); // R9
    AST_DONE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> data_empty); // R9
endmodule

// File: tb/tb_mp_serial_tx.sv
module tb_mp_serial_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cfg_len7 = 1'b0, cfg_two_stop = 1'b0, cfg_mp_en = 1'b0, mp_bit = 1'b0;
    logic       data_irq_en = 1'b1, done_irq_en = 1'b1;
    logic       txd, data_empty, tx_done, irq_data_empty, irq_tx_done;
    int         errors = 0;
    int         checks = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    mp_serial_tx #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_len7(cfg_len7), .cfg_two_stop(cfg_two_stop),
        .cfg_mp_en(cfg_mp_en), .mp_bit(mp_bit), .data_irq_en(data_irq_en),
        .done_irq_en(done_irq_en), .txd(txd), .data_empty(data_empty),
        .tx_done(tx_done), .irq_data_empty(irq_data_empty), .irq_tx_done(irq_tx_done)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(!data_empty && !tx_done, "R2 flags cleared by write",
              int'({data_empty, tx_done}), 0);
    endtask

    task automatic tick(output logic b);
        @(negedge clk);
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        b = txd;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] d, input bit l7, input bit me, input bit mv,
                             input bit ts, input bit chg, input bit wr_next,
                             input logic [7:0] nxt, input string stag);
        logic b;
        int n = l7 ? 7 : 8;
        tick(b);
        check(b == 1'b0, stag, b, 0);
        check(data_empty == 1'b1, "R3 empty set after load", data_empty, 1);
        if (chg) begin
            cfg_len7 = ~cfg_len7; cfg_mp_en = ~cfg_mp_en;
            cfg_two_stop = ~cfg_two_stop; mp_bit = ~mp_bit;
        end
        if (wr_next) host_write(nxt);
        for (int i = 0; i < n; i++) begin
            tick(b);
            check(b == d[i], chg ? "R11 data bit" : "R4 data bit", b, d[i]);
        end
        if (me) begin
            tick(b);
            check(b == mv, chg ? "R11 mp bit" : "R5 mp bit", b, mv);
        end
        tick(b);
        check(b == 1'b1, "R6 first stop", b, 1);
        if (ts) begin
            tick(b);
            check(b == 1'b1, "R6 second stop", b, 1);
        end
    endtask

    task automatic expect_idle_end();
        logic b;
        tick(b);
        check(b == 1'b1, "R9 line mark after frame", b, 1);
        check(tx_done == 1'b1, "R9 done set", tx_done, 1);
        check(irq_tx_done == 1'b1, "R10 done irq", irq_tx_done, 1);
        tick(b);
        check(b == 1'b1 && tx_done, "R9 stays idle", b, 1);
    endtask

    task automatic t_reset();
        check(txd == 1'b1, "R1 txd", txd, 1);
        check(data_empty && tx_done, "R1 flags", int'({data_empty, tx_done}), 3);
        check(irq_data_empty && irq_tx_done, "R10 irqs enabled", int'({irq_data_empty, irq_tx_done}), 3);
        data_irq_en = 1'b0; done_irq_en = 1'b0;
        @(negedge clk);
        check(!irq_data_empty && !irq_tx_done, "R10 irqs masked", int'({irq_data_empty, irq_tx_done}), 0);
        data_irq_en = 1'b1; done_irq_en = 1'b1;
    endtask

    task automatic t_basic8();
        cfg_len7 = 0; cfg_mp_en = 0; cfg_two_stop = 0;
        host_write(8'hA5);
        check(irq_data_empty == 1'b0, "R10 empty irq low while full", irq_data_empty, 0);
        run_frame(8'hA5, 0, 0, 0, 0, 0, 0, 8'h00, "R3 start bit");
        expect_idle_end();
    endtask

    task automatic t_len7_mp1_two();
        cfg_len7 = 1; cfg_mp_en = 1; mp_bit = 1; cfg_two_stop = 1;
        host_write(8'h3C);
        run_frame(8'h3C, 1, 1, 1, 1, 0, 0, 8'h00, "R3 start bit");
        expect_idle_end();
    endtask

    task automatic t_len7_drops_msb();
        logic b;
        cfg_len7 = 1; cfg_mp_en = 0; cfg_two_stop = 0;
        host_write(8'hFF);
        run_frame(8'hFF, 1, 0, 0, 0, 0, 0, 8'h00, "R3 start bit");
        tick(b);
        check(b == 1'b1 && tx_done, "R4 no eighth bit, idle", b, 1);
    endtask

    task automatic t_mp0();
        cfg_len7 = 0; cfg_mp_en = 1; mp_bit = 0; cfg_two_stop = 0;
        host_write(8'hFF);
        run_frame(8'hFF, 0, 1, 0, 0, 0, 0, 8'h00, "R3 start bit");
        expect_idle_end();
    endtask

    task automatic t_bit_hold();
        logic b;
        cfg_len7 = 0; cfg_mp_en = 0; cfg_two_stop = 0;
        host_write(8'h01);
        tick(b);
        check(b == 1'b0, "R3 start bit", b, 0);
        @(negedge clk);
        check(txd == 1'b0, "R7 start held", txd, 0);
        tick(b);
        check(b == 1'b1, "R7 d0 after one tick", b, 1);
        @(negedge clk);
        check(txd == 1'b1, "R7 d0 held", txd, 1);
        for (int i = 1; i < 8; i++) tick(b);
        tick(b);
        expect_idle_end();
    endtask

    task automatic t_chain();
        cfg_len7 = 0; cfg_mp_en = 1; mp_bit = 1; cfg_two_stop = 1;
        host_write(8'h96);
        run_frame(8'h96, 0, 1, 1, 1, 0, 1, 8'h5A, "R3 start bit");
        check(tx_done == 1'b0, "R8 no done before chained frame", tx_done, 0);
        run_frame(8'h5A, 0, 1, 1, 1, 0, 0, 8'h00, "R8 chained start no gap");
        expect_idle_end();
    endtask

    task automatic t_cfg_change();
        cfg_len7 = 0; cfg_mp_en = 1; mp_bit = 0; cfg_two_stop = 0;
        host_write(8'hC3);
        run_frame(8'hC3, 0, 1, 0, 0, 1, 0, 8'h00, "R3 start bit");
        expect_idle_end();
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic8();
        t_len7_mp1_two();
        t_len7_drops_msb();
        t_mp0();
        t_bit_hold();
        t_chain();
        t_cfg_change();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule